// File: doc/BRIEF.md
# Dual-Channel DRAM Rank Decoder

This block turns a physical memory address into a target channel, a rank within that channel and the page-size code of that rank. Software loads a small register file through a byte-wide write port. The register file holds one upper-boundary value and one 3-bit page-size field for each of the four ranks in each of the two channels. Boundary values are cumulative and never decrease. They are counted in 64 MB units. An address belongs to the lowest-numbered rank whose boundary lies above the address's unit count. A rank whose boundary equals the boundary of the rank below it holds no memory.

A mode input chooses how the boundaries are read. In asymmetric mode, channel A's ranks fill the bottom of the address space. Channel B's boundaries are absolute values that continue above the top of channel A. In interleaved mode, address bit 6 picks the channel. That bit is squeezed out of the address before the rank search. Each of channel A's registers then describes a matched pair of ranks, one in each channel. An address that no boundary covers is reported as a miss. The result is registered and appears one cycle after the request.

Top module: `rank_decoder`

## Requirements
- R1: After reset, rsp_valid is 0 and every boundary and page field is 0, so any request made before configuration is answered with rsp_miss=1.
- R2: A write with cfg_we=1 takes effect from the next cycle. A request issued in the same cycle as a write still uses the old contents. Offsets 0-3 hold channel A boundaries for ranks 0-3. Offsets 4-7 hold channel B boundaries for ranks 0-3. Offset 8 holds channel A rank 0 in bits 2:0 and rank 1 in bits 6:4. Offset 9 holds channel A ranks 2 and 3 in the same positions. Offsets 10 and 11 do the same for channel B.
- R3: Writes to offsets 12-15 change no decode result.
- R4: Each request is answered exactly one cycle later: rsp_valid equals req_valid delayed by one clock.
- R5: The unit count is the address shifted right by 26. The selected rank is the lowest rank whose boundary is strictly greater than the unit count.
- R6: A rank whose boundary equals that of the rank below it is never selected.
- R7: With map_mode=0 (asymmetric), channel A is searched first. If no channel A boundary exceeds the unit count, channel B's boundaries are searched with the same unit count, and a hit there gives rsp_chan=1.
- R8: With map_mode=1 (interleaved), rsp_chan equals address bit 6. The unit count is taken from the address with bit 6 removed, which gives address bits 31:27. Channel A's boundary and page registers serve both channels, and channel B's registers have no effect.
- R9: rsp_page is the page field of the selected rank. In asymmetric mode it is taken from the selected channel; in interleaved mode it is taken from channel A.
- R10: When no boundary covers the address, rsp_miss=1 and rsp_chan, rsp_rank and rsp_page are 0.
- R11: While rsp_valid is 0, rsp_miss, rsp_chan, rsp_rank and rsp_page are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 4 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration byte data |
| map_mode | input | 1 | 0 asymmetric, 1 interleaved |
| req_valid | input | 1 | Address request strobe |
| req_addr | input | 32 | Physical address |
| rsp_valid | output | 1 | Decode result valid |
| rsp_miss | output | 1 | Address above all populated ranks |
| rsp_chan | output | 1 | Selected channel (0 = A, 1 = B) |
| rsp_rank | output | 2 | Selected rank |
| rsp_page | output | 3 | Page-size code of the selected rank |

## Verification
The assertions check four things on every cycle: the one-cycle response timing, the zeroed fields on a miss and while idle, and the rule that the interleaved channel follows address bit 6. These properties hold whatever the register contents are. The rank choice itself depends on what software has written, so only the bench scenarios can show it. These scenarios cover empty ranks being skipped, the handover from channel A to channel B, the squeezed address in interleaved mode, the registers that are ignored, and the timing of a write against a request made in the same cycle.

// File: rtl/dram_rank_pkg.sv
package dram_rank_pkg;

    localparam int ADDR_W     = 32;
    localparam int GRAN_SHIFT = 26;
    localparam int BND_W      = 8;
    localparam int NUM_CH     = 2;
    localparam int NUM_RANK   = 4;
    localparam int PAGE_W     = 3;
    localparam int ILV_BIT    = 6;
    localparam int CFG_AW     = 4;
    localparam int CFG_DW     = 8;

    localparam int RANK_W         = $clog2(NUM_RANK);
    localparam int CH_W           = $clog2(NUM_CH);
    localparam int FIELDS_PER_BYTE = 2;
    localparam int FIELD_STRIDE   = CFG_DW / FIELDS_PER_BYTE;
    localparam int BND_BASE       = 0;
    localparam int PAGE_BASE      = BND_BASE + NUM_CH * NUM_RANK;
    localparam int PAGE_BYTES_CH  = NUM_RANK / FIELDS_PER_BYTE;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BND_W-1:0]  bnd_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [RANK_W-1:0] rank_t;
    typedef logic [CH_W-1:0]   chan_t;
    typedef logic [CFG_AW-1:0] cfg_addr_t;
    typedef logic [CFG_DW-1:0] cfg_data_t;

    typedef enum logic {
        MAP_ASYM = 1'b0,
        MAP_ILV  = 1'b1
    } map_mode_e;

    typedef struct packed {
        logic  valid;
        logic  miss;
        chan_t chan;
        rank_t rank;
        page_t page;
    } dec_res_t;

    // Converts an address to boundary units, optionally squeezing out the
    // channel-select bit first.
    function automatic bnd_t units_of(input addr_t a, input logic squeeze);
        addr_t s;
        if (squeeze) begin
            s = {1'b0, a[ADDR_W-1:ILV_BIT+1], a[ILV_BIT-1:0]};
        end else begin
            s = a;
        end
        s = s >> GRAN_SHIFT;
        return bnd_t'(s);
    endfunction

endpackage

// File: rtl/rank_cfg_regs.sv
module rank_cfg_regs
    import dram_rank_pkg::*;
(
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   we,
    input  cfg_addr_t                              addr,
    input  cfg_data_t                              wdata,
    output bnd_t  [NUM_CH-1:0][NUM_RANK-1:0]       bnd_o,
    output page_t [NUM_CH-1:0][NUM_RANK-1:0]       page_o
);

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            for (genvar r = 0; r < NUM_RANK; r++) begin : g_rank
                localparam int BND_OFS  = BND_BASE + ch * NUM_RANK + r;
                localparam int PAGE_OFS = PAGE_BASE + ch * PAGE_BYTES_CH + r / FIELDS_PER_BYTE;
                localparam int LANE     = (r % FIELDS_PER_BYTE) * FIELD_STRIDE;

                logic bnd_hit;
                logic page_hit;
                assign bnd_hit  = we && (addr == cfg_addr_t'(BND_OFS));
                assign page_hit = we && (addr == cfg_addr_t'(PAGE_OFS));

                always_ff @(posedge clk) begin
                    if (rst) begin
                        bnd_o[ch][r]  <= '0;
                        page_o[ch][r] <= '0;
                    end else begin
                        if (bnd_hit) begin
                            bnd_o[ch][r] <= bnd_t'(wdata);
                        end
                        if (page_hit) begin
                            page_o[ch][r] <= wdata[LANE +: PAGE_W];
                        end
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rank_search.sv
module rank_search
    import dram_rank_pkg::*;
(
    input  bnd_t                   unit_i,
    input  bnd_t [NUM_RANK-1:0]    bnd_i,
    output logic                   hit_o,
    output rank_t                  rank_o
);

    logic [NUM_RANK-1:0] below;

    generate
        for (genvar r = 0; r < NUM_RANK; r++) begin : g_cmp
            assign below[r] = unit_i < bnd_i[r];
        end
    endgenerate

    // Lowest-numbered rank whose boundary lies above the unit count.
    always_comb begin
        hit_o  = |below;
        rank_o = '0;
        for (int r = NUM_RANK - 1; r >= 0; r--) begin
            if (below[r]) begin
                rank_o = rank_t'(r);
            end
        end
    end

endmodule

// File: rtl/rank_decoder.sv
module rank_decoder
    import dram_rank_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [CFG_DW-1:0]      cfg_wdata,
    input  logic                   map_mode,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    output logic                   rsp_valid,
    output logic                   rsp_miss,
    output logic [CH_W-1:0]        rsp_chan,
    output logic [RANK_W-1:0]      rsp_rank,
    output logic [PAGE_W-1:0]      rsp_page
);

    bnd_t  [NUM_CH-1:0][NUM_RANK-1:0] bnd;
    page_t [NUM_CH-1:0][NUM_RANK-1:0] page;

    rank_cfg_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .bnd_o  (bnd),
        .page_o (page)
    );

    map_mode_e mode;
    bnd_t      unit_flat;
    bnd_t      unit_sq;
    assign mode      = map_mode_e'(map_mode);
    assign unit_flat = units_of(req_addr, 1'b0);
    assign unit_sq   = units_of(req_addr, 1'b1);

    // Channel 0's searcher serves both modes; the other channels only
    // take part in asymmetric mode.
    bnd_t  [NUM_CH-1:0] unit_in;
    logic  [NUM_CH-1:0] ch_hit;
    rank_t [NUM_CH-1:0] ch_rank;

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_srch
            if (ch == 0) begin : g_first
                assign unit_in[ch] = (mode == MAP_ILV) ? unit_sq : unit_flat;
            end else begin : g_rest
                assign unit_in[ch] = unit_flat;
            end
            rank_search u_srch (
                .unit_i (unit_in[ch]),
                .bnd_i  (bnd[ch]),
                .hit_o  (ch_hit[ch]),
                .rank_o (ch_rank[ch])
            );
        end
    endgenerate

    dec_res_t res_d;
    dec_res_t res_q;

    always_comb begin
        res_d = '0;
        if (req_valid) begin
            res_d.valid = 1'b1;
            if (mode == MAP_ILV) begin
                if (ch_hit[0]) begin
                    res_d.chan = chan_t'(req_addr[ILV_BIT]);
                    res_d.rank = ch_rank[0];
                    res_d.page = page[0][ch_rank[0]];
                end else begin
                    res_d.miss = 1'b1;
                end
            end else begin
                res_d.miss = 1'b1;
                for (int ch = NUM_CH - 1; ch >= 0; ch--) begin
                    if (ch_hit[ch]) begin
                        res_d.miss = 1'b0;
                        res_d.chan = chan_t'(ch);
                        res_d.rank = ch_rank[ch];
                        res_d.page = page[ch][ch_rank[ch]];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign rsp_valid = res_q.valid;
    assign rsp_miss  = res_q.miss;
    assign rsp_chan  = res_q.chan;
    assign rsp_rank  = res_q.rank;
    assign rsp_page  = res_q.page;

endmodule

// File: rtl/rank_decoder_chk.sv
module rank_decoder_chk
    import dram_rank_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 map_mode,
    input logic                 req_valid,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 rsp_valid,
    input logic                 rsp_miss,
    input logic [CH_W-1:0]      rsp_chan,
    input logic [RANK_W-1:0]    rsp_rank,
    input logic [PAGE_W-1:0]    rsp_page
);

    a_r4_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r4_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r10_miss_clears_fields: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_valid && rsp_chan == '0 && rsp_rank == '0 && rsp_page == '0));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_miss && rsp_chan == '0 && rsp_rank == '0 && rsp_page == '0));

    a_r8_ilv_chan_bit: assert property (@(posedge clk) disable iff (rst)
        (req_valid && map_mode) |=> (rsp_miss || rsp_chan == chan_t'($past(req_addr[ILV_BIT]))));

endmodule

bind rank_decoder rank_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .map_mode  (map_mode),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_miss  (rsp_miss),
    .rsp_chan  (rsp_chan),
    .rsp_rank  (rsp_rank),
    .rsp_page  (rsp_page)
);

// File: tb/tb_rank_decoder.sv
`timescale 1ns/1ps
module tb_rank_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_addr;
    logic [7:0]  cfg_wdata;
    logic        map_mode;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        rsp_valid;
    logic        rsp_miss;
    logic        rsp_chan;
    logic [1:0]  rsp_rank;
    logic [2:0]  rsp_page;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rank_decoder dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .map_mode(map_mode), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
        .rsp_chan(rsp_chan), .rsp_rank(rsp_rank), .rsp_page(rsp_page)
    );

    typedef struct packed {
        logic        mode;
        logic [31:0] addr;
        logic        miss;
        logic        chan;
        logic [1:0]  rank;
        logic [2:0]  page;
    } vec_t;

    // Config: A bounds 2,4,4,6 ; B bounds 7,8,8,10
    // A pages 1,2,3,4 ; B pages 5,6,7,0
    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h0000_0000, 1'b0, 1'b0, 2'd0, 3'd1},
        '{1'b0, 32'h0800_0000, 1'b0, 1'b0, 2'd1, 3'd2},
        '{1'b0, 32'h0800_0040, 1'b0, 1'b0, 2'd1, 3'd2},
        '{1'b0, 32'h1000_0000, 1'b0, 1'b0, 2'd3, 3'd4},
        '{1'b0, 32'h17FF_FFFF, 1'b0, 1'b0, 2'd3, 3'd4},
        '{1'b0, 32'h1800_0000, 1'b0, 1'b1, 2'd0, 3'd5},
        '{1'b0, 32'h1C00_0000, 1'b0, 1'b1, 2'd1, 3'd6},
        '{1'b0, 32'h2000_0000, 1'b0, 1'b1, 2'd3, 3'd0},
        '{1'b0, 32'h2400_0000, 1'b0, 1'b1, 2'd3, 3'd0},
        '{1'b0, 32'h2800_0000, 1'b1, 1'b0, 2'd0, 3'd0},
        '{1'b0, 32'hFC00_0000, 1'b1, 1'b0, 2'd0, 3'd0},
        '{1'b1, 32'h0000_0040, 1'b0, 1'b1, 2'd0, 3'd1},
        '{1'b1, 32'h0800_0000, 1'b0, 1'b0, 2'd0, 3'd1},
        '{1'b1, 32'h1000_0040, 1'b0, 1'b1, 2'd1, 3'd2},
        '{1'b1, 32'h2000_0000, 1'b0, 1'b0, 2'd3, 3'd4},
        '{1'b1, 32'h2800_0040, 1'b0, 1'b1, 2'd3, 3'd4},
        '{1'b1, 32'h3000_0040, 1'b1, 1'b0, 2'd0, 3'd0}
    };

    task automatic expect_rsp(input string req, input logic v, input logic m,
                              input logic c, input logic [1:0] r, input logic [2:0] p);
        checks++;
        if (rsp_valid !== v || rsp_miss !== m || rsp_chan !== c ||
            rsp_rank !== r || rsp_page !== p) begin
            errors++;
            $display("FAIL %s: got v=%0b m=%0b c=%0b r=%0d p=%0d exp v=%0b m=%0b c=%0b r=%0d p=%0d",
                     req, rsp_valid, rsp_miss, rsp_chan, rsp_rank, rsp_page, v, m, c, r, p);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic issue(input logic m, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; map_mode = m; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic load_config();
        cfg_write(4'd0, 8'd2);  cfg_write(4'd1, 8'd4);
        cfg_write(4'd2, 8'd4);  cfg_write(4'd3, 8'd6);
        cfg_write(4'd4, 8'd7);  cfg_write(4'd5, 8'd8);
        cfg_write(4'd6, 8'd8);  cfg_write(4'd7, 8'd10);
        cfg_write(4'd8, 8'h21); cfg_write(4'd9, 8'h43);
        cfg_write(4'd10, 8'h65); cfg_write(4'd11, 8'h07);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        map_mode = 1'b0; req_valid = 1'b0; req_addr = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state and unconfigured decode
        expect_rsp("R1 reset idle", 1'b0, 1'b0, 1'b0, 2'd0, 3'd0);
        issue(1'b0, 32'h0000_0000);
        expect_rsp("R1 unconfigured miss", 1'b1, 1'b1, 1'b0, 2'd0, 3'd0);
        // R11: idle after response
        @(negedge clk);
        expect_rsp("R11 idle quiet", 1'b0, 1'b0, 1'b0, 2'd0, 3'd0);

        load_config();

        // R5 R6 R7 R8 R9 R10 table walk
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i].mode, VEC[i].addr);
            expect_rsp($sformatf("R5/R7/R8/R9/R10 vector %0d", i), 1'b1,
                       VEC[i].miss, VEC[i].chan, VEC[i].rank, VEC[i].page);
        end

        // R3: writes to unused offsets change nothing
        cfg_write(4'd12, 8'h00); cfg_write(4'd13, 8'h00);
        cfg_write(4'd14, 8'hFF); cfg_write(4'd15, 8'h00);
        issue(1'b0, 32'h0000_0000);
        expect_rsp("R3 unused offsets A r0", 1'b1, 1'b0, 1'b0, 2'd0, 3'd1);
        issue(1'b0, 32'h2400_0000);
        expect_rsp("R3 unused offsets B r3", 1'b1, 1'b0, 1'b1, 2'd3, 3'd0);

        // R8: channel B registers ignored in interleaved mode
        cfg_write(4'd4, 8'd0);
        cfg_write(4'd10, 8'h77);
        issue(1'b1, 32'h0000_0040);
        expect_rsp("R8 B regs ignored", 1'b1, 1'b0, 1'b1, 2'd0, 3'd1);
        // R6/R7: B rank0 now empty, asym unit 6 lands in B rank1
        issue(1'b0, 32'h1800_0000);
        expect_rsp("R6 empty B rank0 skipped", 1'b1, 1'b0, 1'b1, 2'd1, 3'd7);

        // R2: write in same cycle as request uses old value
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 8'd3;
        req_valid = 1'b1; map_mode = 1'b0; req_addr = 32'h0800_0000;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        expect_rsp("R2 same-cycle old value", 1'b1, 1'b0, 1'b0, 2'd1, 3'd2);
        issue(1'b0, 32'h0800_0000);
        expect_rsp("R2 next-cycle new value", 1'b1, 1'b0, 1'b0, 2'd0, 3'd1);

        // R4: back-to-back requests, one response each cycle later
        @(negedge clk);
        req_valid = 1'b1; map_mode = 1'b0; req_addr = 32'h0000_0000;
        @(negedge clk);
        req_addr = 32'hFC00_0000;
        expect_rsp("R4 back-to-back first", 1'b1, 1'b0, 1'b0, 2'd0, 3'd1);
        @(negedge clk);
        req_valid = 1'b0;
        expect_rsp("R4 back-to-back second", 1'b1, 1'b1, 1'b0, 2'd0, 3'd0);
        @(negedge clk);
        expect_rsp("R4 response drops", 1'b0, 1'b0, 1'b0, 2'd0, 3'd0);

        // R1: reset clears configuration again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        issue(1'b1, 32'h0000_0040);
        expect_rsp("R1 reset clears config", 1'b1, 1'b1, 1'b0, 2'd0, 3'd0);

        finish_run();
    end

endmodule